// File: doc/BRIEF.md
# Handshake Pin Function Multiplexer

This block sits between the upper four bits of a general-purpose output port and the package pins. After reset the four pins simply follow their port latch bits. Firmware can switch them into alternate handshake roles with two command strobes. One command turns the lower two pins into interrupt lines that report the state of the host interface buffers. The other turns the upper two pins into a DMA request output and a DMA acknowledge input.

In the interrupt role each port latch bit no longer drives its pin. It acts as a gate on a live buffer status flag. In the DMA role the request is raised when firmware writes the port. A hardware acknowledge cycle from the host then drops it. While the acknowledge input is low, the block produces the buffer select for the host data registers. It does this without needing chip select, and it forces the data address, so a DMA transfer cannot reach the status or command path.

Top module: `hs_pin_func_mux`

## Requirements
- R1: After reset both roles are off and the request is low: pin_out equals port_bits for every value of port_bits, obf and ibf.
- R2: In interrupt mode, pin_out[0] equals port_bits[0] AND obf. It is low whenever port_bits[0] is 0.
- R3: In interrupt mode, pin_out[1] equals port_bits[1] AND NOT ibf. It is low whenever port_bits[1] is 0.
- R4: Each mode is set by a one-cycle pulse on its command input and takes effect on the next cycle. It stays set until reset, and a repeated pulse leaves it set. Interrupt mode does not change pin_out[3:2].
- R5: In DMA mode, pin_out[2] shows the request rather than port_bits[2]. A port_wr pulse with port_bits[2]=1 raises the request on the next cycle. A port write with port_bits[2]=0 leaves the request unchanged.
- R6: The request stays high while a read or write strobe is held low with dack_n low. It drops in the cycle after the strobe rises (its trailing edge). An acknowledge without a strobe, or a strobe without an acknowledge, leaves it high.
- R7: An en_dma_cmd pulse clears the request on the next cycle. This clear takes priority over a port write in the same cycle.
- R8: In DMA mode pin_out[3] is driven 1, which releases the quasi-bidirectional pin so it can act as the acknowledge input.
- R9: buf_sel is active high. With no DMA acknowledge active, buf_sel = NOT cs_n and buf_cmd = a0. This holds before DMA mode is enabled, even if dack_n is low. In DMA mode with dack_n low, buf_sel = 1 and buf_cmd = 0, whatever cs_n and a0 are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_bits | input | 4 | Port latch bits for the four multiplexed pins |
| port_wr | input | 1 | Pulse: firmware wrote the port latch this cycle |
| en_flags_cmd | input | 1 | Pulse: enable the buffer interrupt roles |
| en_dma_cmd | input | 1 | Pulse: enable the DMA roles and clear the request |
| obf | input | 1 | Output buffer full status flag |
| ibf | input | 1 | Input buffer full status flag |
| dack_n | input | 1 | DMA acknowledge pin, active low |
| cs_n | input | 1 | Host chip select, active low |
| a0 | input | 1 | Host address: 1 selects command/status, 0 selects data |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| pin_out | output | 4 | Drive values for the four pins |
| buf_sel | output | 1 | Buffer register select, active high |
| buf_cmd | output | 1 | Address to the buffer registers (1 = command/status path) |

## Verification
In each of three mode states (no role, interrupt role, both roles) the pin mapping is swept over all sixteen port latch values and all four obf/ibf combinations. This sweep separates direct drive from gating and catches polarity slips on the input-full line. The buffer select is swept over cs_n, a0 and dack_n before and after DMA mode. That shows the acknowledge is ignored until the mode is on, and that it then overrides the address. Request sequences cover several cases: acknowledged reads and writes, with the request sampled during the strobe and after its trailing edge; acknowledge-only and strobe-only cycles; writes with the request bit cleared; and a re-enable command colliding with a port write.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned PIN_W     = 4;
  localparam int unsigned OFULL_IDX = 0;
  localparam int unsigned IFULL_IDX = 1;
  localparam int unsigned DREQ_IDX  = 2;
  localparam int unsigned DACK_IDX  = 3;

  typedef struct packed {
    logic flags_on;
    logic dma_on;
  } hs_mode_t;
endpackage

// File: rtl/hs_mode_reg.sv
module hs_mode_reg
  import hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_flags_cmd,
  input  logic     en_dma_cmd,
  output hs_mode_t mode
);
  hs_mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (en_flags_cmd) mode_d.flags_on = 1'b1;
    if (en_dma_cmd)   mode_d.dma_on   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.flags_on |=> mode_q.flags_on);
  assert_dma_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.dma_on |=> mode_q.dma_on);
  assert_flags_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q.flags_on) |-> $past(en_flags_cmd));
endmodule

// File: rtl/hs_drq_ctrl.sv
module hs_drq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_on,
  input  logic en_dma_cmd,
  input  logic port_wr,
  input  logic req_bit,
  input  logic dack_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic drq
);
  logic drq_q, drq_d;
  logic acc_q, acc_d;
  logic strobes_idle, acc_end, req_set;

  assign strobes_idle = rd_n & wr_n;
  assign acc_d        = dma_on & ~dack_n & ~strobes_idle;
  assign acc_end      = acc_q & strobes_idle;
  assign req_set      = dma_on & port_wr & req_bit;

  always_comb begin
    drq_d = drq_q;
    if (en_dma_cmd || acc_end) drq_d = 1'b0;
    else if (req_set)          drq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      drq_q <= drq_d;
      acc_q <= acc_d;
    end
  end

  assign drq = drq_q;

  assert_drq_rise_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq_q) |-> $past(port_wr && req_bit && !en_dma_cmd));
  assert_drq_clr_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_dma_cmd |=> !drq_q);
  assert_drq_clr_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> !drq_q);
  assert_drq_hold_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drq_q && !strobes_idle && !en_dma_cmd) |=> drq_q);
endmodule

// File: rtl/hs_pin_mux.sv
module hs_pin_mux
  import hs_pkg::*;
(
  input  hs_mode_t         mode,
  input  logic [PIN_W-1:0] port_bits,
  input  logic             obf,
  input  logic             ibf,
  input  logic             drq,
  output logic [PIN_W-1:0] pin_out
);
  logic [PIN_W-1:0] alt_val;
  logic [PIN_W-1:0] alt_sel;

  always_comb begin
    alt_val            = '0;
    alt_val[OFULL_IDX] = port_bits[OFULL_IDX] & obf;
    alt_val[IFULL_IDX] = port_bits[IFULL_IDX] & ~ibf;
    alt_val[DREQ_IDX]  = drq;
    alt_val[DACK_IDX]  = 1'b1;
    alt_sel            = '0;
    alt_sel[OFULL_IDX] = mode.flags_on;
    alt_sel[IFULL_IDX] = mode.flags_on;
    alt_sel[DREQ_IDX]  = mode.dma_on;
    alt_sel[DACK_IDX]  = mode.dma_on;
  end

  for (genvar gi = 0; gi < PIN_W; gi++) begin : g_pin
    assign pin_out[gi] = alt_sel[gi] ? alt_val[gi] : port_bits[gi];
  end

  always_comb begin
    assert_ofull_gate_R2: assert (!(mode.flags_on && !port_bits[OFULL_IDX]) || !pin_out[OFULL_IDX]);
    assert_ifull_gate_R3: assert (!(mode.flags_on && !port_bits[IFULL_IDX]) || !pin_out[IFULL_IDX]);
    assert_ack_release_R8: assert (!mode.dma_on || pin_out[DACK_IDX]);
  end
endmodule

// File: rtl/hs_pin_func_mux.sv
module hs_pin_func_mux
  import hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] port_bits,
  input  logic             port_wr,
  input  logic             en_flags_cmd,
  input  logic             en_dma_cmd,
  input  logic             obf,
  input  logic             ibf,
  input  logic             dack_n,
  input  logic             cs_n,
  input  logic             a0,
  input  logic             rd_n,
  input  logic             wr_n,
  output logic [PIN_W-1:0] pin_out,
  output logic             buf_sel,
  output logic             buf_cmd
);
  hs_mode_t mode;
  logic     drq;
  logic     dma_ack;

  hs_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_flags_cmd (en_flags_cmd),
    .en_dma_cmd   (en_dma_cmd),
    .mode         (mode)
  );

  hs_drq_ctrl u_drq (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_on     (mode.dma_on),
    .en_dma_cmd (en_dma_cmd),
    .port_wr    (port_wr),
    .req_bit    (port_bits[DREQ_IDX]),
    .dack_n     (dack_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .drq        (drq)
  );

  hs_pin_mux u_mux (
    .mode      (mode),
    .port_bits (port_bits),
    .obf       (obf),
    .ibf       (ibf),
    .drq       (drq),
    .pin_out   (pin_out)
  );

  assign dma_ack = mode.dma_on & ~dack_n;
  assign buf_sel = dma_ack | ~cs_n;
  assign buf_cmd = dma_ack ? 1'b0 : a0;

  assert_ack_data_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.dma_on && !dack_n) |-> (buf_sel && !buf_cmd));
  assert_no_drq_pin_before_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.dma_on |-> (pin_out[DREQ_IDX] == port_bits[DREQ_IDX]));
endmodule

// File: tb/hs_pin_func_mux_bench.sv
module hs_pin_func_mux_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] port_bits;
  logic       port_wr, en_flags_cmd, en_dma_cmd, obf, ibf;
  logic       dack_n, cs_n, a0, rd_n, wr_n;
  logic [3:0] pin_out;
  logic       buf_sel, buf_cmd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  hs_pin_func_mux u_hs_pin_func_mux (
    .clk(clk), .rst_n(rst_n), .port_bits(port_bits), .port_wr(port_wr),
    .en_flags_cmd(en_flags_cmd), .en_dma_cmd(en_dma_cmd), .obf(obf), .ibf(ibf),
    .dack_n(dack_n), .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n),
    .pin_out(pin_out), .buf_sel(buf_sel), .buf_cmd(buf_cmd)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_cmd(input bit fl, input bit dm, input bit pw);
    en_flags_cmd = fl; en_dma_cmd = dm; port_wr = pw;
    next_cycle();
    en_flags_cmd = 0; en_dma_cmd = 0; port_wr = 0;
    #1;
  endtask

  function automatic logic [3:0] exp_pins(input logic [3:0] p, input bit o, input bit i,
                                         input bit fl, input bit dm, input bit rq);
    logic [3:0] e;
    e = p;
    if (fl) begin
      e[0] = p[0] & o;
      e[1] = p[1] & ~i;
    end
    if (dm) begin
      e[2] = rq;
      e[3] = 1'b1;
    end
    return e;
  endfunction

  task automatic sweep_pins(input string req, input bit fl, input bit dm, input bit rq);
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 4; s++) begin
        port_bits = p[3:0]; obf = s[0]; ibf = s[1];
        #1;
        check(req, pin_out, exp_pins(p[3:0], s[0], s[1], fl, dm, rq));
      end
    end
    port_bits = 4'b0000; obf = 0; ibf = 0;
    #1;
  endtask

  task automatic sweep_sel(input string req, input bit dm);
    for (int v = 0; v < 8; v++) begin
      cs_n = v[0]; a0 = v[1]; dack_n = v[2];
      #1;
      if (dm && !v[2]) check(req, {2'b00, buf_sel, buf_cmd}, 4'b0010);
      else             check(req, {2'b00, buf_sel, buf_cmd}, {2'b00, ~v[0], v[1]});
    end
    cs_n = 1; a0 = 0; dack_n = 1;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; port_bits = 0; port_wr = 0; en_flags_cmd = 0; en_dma_cmd = 0;
    obf = 0; ibf = 0; dack_n = 1; cs_n = 1; a0 = 0; rd_n = 1; wr_n = 1;
    repeat (3) next_cycle();
    rst_n = 1;
    next_cycle();

    // R1: plain port pins after reset
    sweep_pins("R1", 0, 0, 0);
    // R9: acknowledge ignored before DMA mode
    sweep_sel("R9 pre-dma", 0);
    // R5: port write before DMA mode raises no request (pin2 follows port)
    port_bits = 4'b0100; pulse_cmd(0, 0, 1);
    port_bits = 4'b0000; #1;
    check("R5 no req before dma", {3'b000, pin_out[2]}, 4'b0000);

    // R4/R2/R3: interrupt mode
    pulse_cmd(1, 0, 0);
    sweep_pins("R2/R3 flags", 1, 0, 0);
    pulse_cmd(1, 0, 0);
    sweep_pins("R4 flags repeat", 1, 0, 0);

    // DMA mode
    pulse_cmd(0, 1, 0);
    sweep_pins("R5/R8 dma idle", 1, 1, 0);
    sweep_sel("R9 dma", 1);
    port_bits = 4'b0000; pulse_cmd(0, 0, 1);
    check("R5 write bit0 no req", pin_out, exp_pins(4'b0000, 0, 0, 1, 1, 0));
    port_bits = 4'b0100; pulse_cmd(0, 0, 1);
    check("R5 write bit1 req", pin_out, exp_pins(4'b0100, 0, 0, 1, 1, 1));
    port_bits = 4'b0000; #1;
    check("R5 pin shows req not port", pin_out, exp_pins(4'b0000, 0, 0, 1, 1, 1));
    port_bits = 4'b0000; pulse_cmd(0, 0, 1);
    check("R5 write 0 keeps req", {3'b000, pin_out[2]}, 4'b0001);

    // R6: acknowledged read
    dack_n = 0; rd_n = 0; cs_n = 1; a0 = 1; next_cycle();
    check("R9 ack overrides", {2'b00, buf_sel, buf_cmd}, 4'b0010);
    check("R6 hold during read", {3'b000, pin_out[2]}, 4'b0001);
    next_cycle();
    check("R6 hold during read 2", {3'b000, pin_out[2]}, 4'b0001);
    rd_n = 1; #1;
    check("R6 hold at trailing edge", {3'b000, pin_out[2]}, 4'b0001);
    next_cycle();
    check("R6 clear after read", {3'b000, pin_out[2]}, 4'b0000);
    dack_n = 1; a0 = 0; #1;

    // R6: acknowledged write
    port_bits = 4'b0100; pulse_cmd(0, 0, 1);
    check("R6 req set again", {3'b000, pin_out[2]}, 4'b0001);
    dack_n = 0; wr_n = 0; next_cycle();
    check("R6 hold during write", {3'b000, pin_out[2]}, 4'b0001);
    wr_n = 1; dack_n = 1; next_cycle();
    check("R6 clear after write", {3'b000, pin_out[2]}, 4'b0000);

    // R6: ack only, strobe only
    pulse_cmd(0, 0, 1);
    dack_n = 0; repeat (3) next_cycle();
    dack_n = 1; next_cycle();
    check("R6 ack without strobe", {3'b000, pin_out[2]}, 4'b0001);
    cs_n = 0; rd_n = 0; repeat (2) next_cycle();
    rd_n = 1; cs_n = 1; next_cycle(); next_cycle();
    check("R6 strobe without ack", {3'b000, pin_out[2]}, 4'b0001);

    // R7: re-enable clears, wins over write
    pulse_cmd(0, 1, 0);
    check("R7 reenable clears", {3'b000, pin_out[2]}, 4'b0000);
    pulse_cmd(0, 1, 1);
    check("R7 clear beats write", {3'b000, pin_out[2]}, 4'b0000);
    pulse_cmd(0, 0, 1);
    check("R7 req after collision", {3'b000, pin_out[2]}, 4'b0001);
    sweep_pins("R4/R8 modes kept", 1, 1, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule